// File: doc/BRIEF.md
# Maskable Interrupt Subclass Pending Controller

This block collects I/O interruption requests posted by many subchannels and holds them until a processor takes them. Each posted request carries a subchannel id and one of eight interruption subclasses. Each subclass keeps its own first-in, first-out queue of eight entries. Subclass 0 has the highest priority and subclass 7 the lowest.

Each processor has a mask register with one enable bit per subclass. Bit k enables subclass k. A processor's interrupt line is raised whenever a subclass that its mask enables holds at least one request. An acknowledge takes the oldest request of the highest-priority enabled non-empty subclass. The subchannel id and the subclass come back combinationally in that cycle, and the entry is removed at the clock edge that ends the cycle.

An acknowledge may also be issued without a raised line, so that a handler can pull the next pending request without taking a new interrupt. A request whose subclass no processor enables is held, not dropped. A test query that names a subclass collects such a request regardless of any mask. When processors contend in one cycle, the lower-numbered processor is served first. Each subclass gives up at most one entry per cycle, so no request is ever delivered twice.

Top module: `isc_ctrl`

## Requirements
- R1: After reset every queue is empty and every mask is zero. Every interrupt line is low, and no grant is valid, even with acknowledge asserted.
- R2: A post carries an id and a 3-bit subclass (0 to 7). It appends the id to that subclass's queue, which holds 8 entries. A post to a full queue is ignored.
- R3: The interrupt line of processor c is high exactly when some subclass k is non-empty and bit k of c's mask is 1.
- R4: An acknowledge returns, in the same cycle, a valid grant with the id and subclass of the lowest-numbered non-empty subclass that the mask enables. That entry is gone from the next cycle on.
- R5: Requests within one subclass are granted in the order they were posted.
- R6: An acknowledge with no enabled pending request returns no valid grant and removes nothing.
- R7: A request in a subclass masked by every processor stays pending until it is collected.
- R8: A test query naming subclass k returns and removes the head of queue k whatever the masks hold. If queue k is empty, no grant is returned.
- R9: When several processors request in the same cycle, they are served in ascending processor order. A subclass already claimed in that cycle is skipped by higher-numbered processors, which take the next eligible subclass instead.
- R10: When a processor issues a query and an acknowledge in the same cycle, the query is served and the acknowledge has no effect.
- R11: A mask write for processor c loads the mask data into c's mask at the clock edge. It affects the interrupt line and the grants from the next cycle on.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| post_valid | input | 1 | Post a request this cycle |
| post_sch | input | SCH_W | Subchannel id of the posted request |
| post_cls | input | 3 | Subclass of the posted request |
| mask_wr | input | NCPU | Per-processor mask write enable |
| mask_din | input | 8 | Mask data, bit k enables subclass k |
| ack | input | NCPU | Per-processor acknowledge / test-pending request |
| qry | input | NCPU | Per-processor test query |
| qry_cls | input | NCPU*3 | Subclass named by each processor's query |
| irq_pend | output | NCPU | Per-processor interrupt-pending line |
| gnt_valid | output | NCPU | Grant returned to each processor this cycle |
| gnt_sch | output | NCPU*SCH_W | Granted subchannel id per processor |
| gnt_cls | output | NCPU*3 | Granted subclass per processor |

## Verification
The embedded assertions watch, on every cycle, that no subclass is claimed by two processors at once. They also watch that an acknowledge grant lands only in a subclass the requester enables, that a queue is never popped when empty or pushed past its depth, and that its fill level moves only with a push or a pop. Only the bench's scenarios can show that grants come out in priority order and in posting order, that masked requests survive and are later collected, that a full queue ignores a post, and how contending processors split the work. A scoreboard model of the eight queues supplies the expected results for these scenarios.

// File: rtl/isc_pkg.sv
package isc_pkg;
   localparam int ISC_NCLS  = 8;
   localparam int ISC_CLS_W = $clog2(ISC_NCLS);

   // lowest set bit as a one-hot vector (priority: index 0 wins)
   function automatic logic [ISC_NCLS-1:0] isc_lowest(input logic [ISC_NCLS-1:0] v);
      logic [ISC_NCLS-1:0] r;
      r = '0;
      for (int i = ISC_NCLS - 1; i >= 0; i--) begin
         if (v[i]) r = ISC_NCLS'(1) << i;
      end
      return r;
   endfunction
endpackage

// File: rtl/isc_fifo.sv
module isc_fifo #(
   parameter int DEPTH = 8,
   parameter int W     = 8
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         push,
   input  logic [W-1:0] din,
   input  logic         pop,
   output logic [W-1:0] head,
   output logic         empty,
   output logic         full
);
   localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
   localparam int CW = PW + 1;

   if (DEPTH < 2 || (DEPTH & (DEPTH - 1)) != 0) begin : g_bad_depth
      $error("isc_fifo: DEPTH must be a power of two of at least 2");
   end

   logic [W-1:0]  mem [DEPTH];
   logic [PW-1:0] wp, rp;
   logic [CW-1:0] cnt;
   logic          do_push, do_pop;

   assign empty   = (cnt == '0);
   assign full    = (cnt == CW'(DEPTH));
   assign head    = mem[rp];
   assign do_push = push && !full;
   assign do_pop  = pop && !empty;

   always_ff @(posedge clk) begin
      if (do_push) mem[wp] <= din;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wp  <= '0;
         rp  <= '0;
         cnt <= '0;
      end else begin
         if (do_push) wp <= wp + PW'(1);
         if (do_pop)  rp <= rp + PW'(1);
         cnt <= cnt + CW'(do_push) - CW'(do_pop);
      end
   end

   // R6
   pop_nonempty_chk: assert property (@(posedge clk) disable iff (!rst_n) pop |-> !empty);
   // R2
   no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n) cnt <= CW'(DEPTH));
   // R7
   hold_level_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!push && !pop) |=> $stable(cnt));
endmodule

// File: rtl/isc_pick.sv
module isc_pick
   import isc_pkg::*;
(
   input  logic [ISC_NCLS-1:0]  want,
   output logic [ISC_NCLS-1:0]  sel,
   output logic [ISC_CLS_W-1:0] idx,
   output logic                 hit
);
   always_comb begin
      sel = isc_lowest(want);
      idx = '0;
      for (int i = 0; i < ISC_NCLS; i++) begin
         if (sel[i]) idx = ISC_CLS_W'(i);
      end
      hit = |want;
   end
endmodule

// File: rtl/isc_ctrl.sv
module isc_ctrl
   import isc_pkg::*;
#(
   parameter int NCPU  = 2,
   parameter int SCH_W = 8,
   parameter int DEPTH = 8
) (
   input  logic                      clk,
   input  logic                      rst_n,
   input  logic                      post_valid,
   input  logic [SCH_W-1:0]          post_sch,
   input  logic [ISC_CLS_W-1:0]      post_cls,
   input  logic [NCPU-1:0]           mask_wr,
   input  logic [ISC_NCLS-1:0]       mask_din,
   input  logic [NCPU-1:0]           ack,
   input  logic [NCPU-1:0]           qry,
   input  logic [NCPU*ISC_CLS_W-1:0] qry_cls,
   output logic [NCPU-1:0]           irq_pend,
   output logic [NCPU-1:0]           gnt_valid,
   output logic [NCPU*SCH_W-1:0]     gnt_sch,
   output logic [NCPU*ISC_CLS_W-1:0] gnt_cls
);
   if (NCPU < 1 || SCH_W < 1) begin : g_bad_param
      $error("isc_ctrl: NCPU and SCH_W must be positive");
   end

   logic [SCH_W-1:0]    head [ISC_NCLS];
   logic [ISC_NCLS-1:0] nonempty;
   logic [ISC_NCLS-1:0] taken [NCPU+1];
   logic [ISC_NCLS-1:0] sel_v [NCPU];
   logic [ISC_NCLS-1:0] mask_q [NCPU];

   assign taken[0] = '0;

   for (genvar k = 0; k < ISC_NCLS; k++) begin : g_cls
      logic emp, ful;
      isc_fifo #(.DEPTH(DEPTH), .W(SCH_W)) u_q (
         .clk  (clk),
         .rst_n(rst_n),
         .push (post_valid && post_cls == ISC_CLS_W'(k)),
         .din  (post_sch),
         .pop  (taken[NCPU][k]),
         .head (head[k]),
         .empty(emp),
         .full (ful)
      );
      assign nonempty[k] = !emp;

      logic [NCPU-1:0] col;
      for (genvar c = 0; c < NCPU; c++) begin : g_col
         assign col[c] = sel_v[c][k];
      end
      // R9
      single_claim_chk: assert property (@(posedge clk) disable iff (!rst_n) $onehot0(col));
   end

   for (genvar c = 0; c < NCPU; c++) begin : g_cpu
      logic [ISC_NCLS-1:0]  avail, want, qsel;
      logic [ISC_CLS_W-1:0] idx, qc;
      logic                 hit;

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)          mask_q[c] <= '0;
         else if (mask_wr[c]) mask_q[c] <= mask_din;
      end

      assign qc    = qry_cls[c*ISC_CLS_W +: ISC_CLS_W];
      assign qsel  = ISC_NCLS'(1) << qc;
      assign avail = nonempty & ~taken[c];
      assign want  = qry[c] ? (qsel & avail)
                   : (ack[c] ? (mask_q[c] & avail) : '0);

      isc_pick u_pick (.want(want), .sel(sel_v[c]), .idx(idx), .hit(hit));

      assign taken[c+1]                        = taken[c] | sel_v[c];
      assign irq_pend[c]                       = |(nonempty & mask_q[c]);
      assign gnt_valid[c]                      = hit;
      assign gnt_sch[c*SCH_W +: SCH_W]         = hit ? head[idx] : '0;
      assign gnt_cls[c*ISC_CLS_W +: ISC_CLS_W] = idx;

      // R4
      ack_enabled_chk: assert property (@(posedge clk) disable iff (!rst_n)
         (gnt_valid[c] && !qry[c]) |-> mask_q[c][idx]);
      // R10
      qry_target_chk: assert property (@(posedge clk) disable iff (!rst_n)
         (gnt_valid[c] && qry[c]) |-> (idx == qc));
   end
endmodule

// File: tb/isc_ctrl_test.sv
module isc_ctrl_test;
   localparam int NCPU = 2, SCH_W = 8, NCLS = 8, CW = 3;

   logic clk = 0, rst_n = 0;
   logic post_valid = 0;
   logic [SCH_W-1:0] post_sch = '0;
   logic [CW-1:0] post_cls = '0;
   logic [NCPU-1:0] mask_wr = '0, ack = '0, qry = '0;
   logic [NCLS-1:0] mask_din = '0;
   logic [NCPU*CW-1:0] qry_cls = '0;
   logic [NCPU-1:0] irq_pend, gnt_valid;
   logic [NCPU*SCH_W-1:0] gnt_sch;
   logic [NCPU*CW-1:0] gnt_cls;

   int errors = 0, checks = 0;
   logic [SCH_W-1:0] mq [NCLS][$];
   logic [NCLS-1:0] mmask [NCPU];

   always #10 clk = ~clk;

   isc_ctrl #(.NCPU(NCPU), .SCH_W(SCH_W), .DEPTH(8)) uut (
      .clk(clk), .rst_n(rst_n), .post_valid(post_valid), .post_sch(post_sch),
      .post_cls(post_cls), .mask_wr(mask_wr), .mask_din(mask_din), .ack(ack),
      .qry(qry), .qry_cls(qry_cls), .irq_pend(irq_pend), .gnt_valid(gnt_valid),
      .gnt_sch(gnt_sch), .gnt_cls(gnt_cls));

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   function automatic logic [NCPU-1:0] exp_irq();
      logic [NCPU-1:0] r = '0;
      for (int c = 0; c < NCPU; c++)
         for (int k = 0; k < NCLS; k++)
            if (mq[k].size() > 0 && mmask[c][k]) r[c] = 1'b1;
      return r;
   endfunction

   // driver: posting pushes into the scoreboard model
   task automatic post(input logic [SCH_W-1:0] id, input int cls);
      @(negedge clk);
      post_valid = 1; post_sch = id; post_cls = CW'(cls);
      if (mq[cls].size() < 8) mq[cls].push_back(id);
      @(posedge clk); #1 post_valid = 0;
   endtask

   task automatic set_mask(input int c, input logic [NCLS-1:0] m);
      @(negedge clk);
      mask_wr[c] = 1; mask_din = m; mmask[c] = m;
      @(posedge clk); #1 mask_wr = '0;
   endtask

   // monitor: one cycle of acks/queries, expected popped from the model
   task automatic serve(input string req, input logic [NCPU-1:0] a,
                        input logic [NCPU-1:0] q, input int qc0, input int qc1);
      logic [NCLS-1:0] claimed = '0;
      @(negedge clk);
      ack = a; qry = q; qry_cls = {CW'(qc1), CW'(qc0)};
      #2;
      chk({req, " irq"}, 32'(irq_pend), 32'(exp_irq()));
      for (int c = 0; c < NCPU; c++) begin
         int pick = -1;
         if (q[c]) begin
            int k = (c == 0) ? qc0 : qc1;
            if (mq[k].size() > 0 && !claimed[k]) pick = k;
         end else if (a[c]) begin
            for (int k = NCLS - 1; k >= 0; k--)
               if (mq[k].size() > 0 && mmask[c][k] && !claimed[k]) pick = k;
         end
         chk({req, " valid"}, 32'(gnt_valid[c]), 32'(pick >= 0));
         if (pick >= 0) begin
            claimed[pick] = 1'b1;
            chk({req, " id"}, 32'(gnt_sch[c*SCH_W +: SCH_W]), 32'(mq[pick][0]));
            chk({req, " cls"}, 32'(gnt_cls[c*CW +: CW]), 32'(pick));
         end
      end
      @(posedge clk); #1;
      ack = '0; qry = '0;
      for (int k = 0; k < NCLS; k++) if (claimed[k]) void'(mq[k].pop_front());
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      errors++; checks++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      for (int c = 0; c < NCPU; c++) mmask[c] = '0;
      repeat (3) @(posedge clk);
      #1 rst_n = 1;
      // R1: reset state, acknowledge on empty
      serve("R1", 2'b11, 2'b00, 0, 0);
      // R11 R3 R7: mask selects class 2 only; class 5 masked by all
      set_mask(0, 8'b0000_0100);
      post(8'h11, 5);
      @(negedge clk); chk("R7 irq masked", 32'(irq_pend), 32'(0));
      post(8'h22, 2);
      @(negedge clk); chk("R3 irq raised", 32'(irq_pend), 32'(2'b01));
      serve("R4", 2'b01, 2'b00, 0, 0);
      // R6: nothing enabled left, class 5 still held
      serve("R6", 2'b01, 2'b00, 0, 0);
      serve("R6 again", 2'b01, 2'b00, 0, 0);
      // R8: query collects masked request, then empty query
      serve("R8 R7", 2'b00, 2'b10, 0, 5);
      serve("R8 empty", 2'b00, 2'b10, 0, 5);
      // R5 R4: FIFO and priority
      set_mask(0, 8'hFF);
      post(8'h31, 3); post(8'h32, 3); post(8'h33, 3); post(8'h10, 1);
      for (int i = 0; i < 5; i++) serve("R5 R4", 2'b01, 2'b00, 0, 0);
      // R2: full queue ignores ninth post
      for (int i = 0; i < 9; i++) post(8'h70 + 8'(i), 7);
      for (int i = 0; i < 9; i++) serve("R2", 2'b00, 2'b01, 7, 0);
      // R9: contention
      set_mask(1, 8'hFF);
      post(8'h41, 4); post(8'h42, 4); post(8'h61, 6);
      serve("R9", 2'b11, 2'b00, 0, 0);
      serve("R9 next", 2'b11, 2'b00, 0, 0);
      // R10: query beats acknowledge on one processor
      post(8'h01, 0); post(8'h62, 6);
      serve("R10", 2'b01, 2'b01, 6, 0);
      serve("R10 after", 2'b01, 2'b00, 0, 0);
      // R11 R3: mask clear on cpu1 drops its line
      set_mask(1, 8'h00);
      post(8'h05, 0);
      @(negedge clk); chk("R11 irq", 32'(irq_pend), 32'(2'b01));
      serve("R11", 2'b11, 2'b00, 0, 0);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule